// File: doc/BRIEF.md
# Watchpoint-to-Breakpoint Trigger Unit

This block sits between the watchpoint comparators of a processor core and its exception logic. Every watchpoint match strobe is passed straight to a dedicated indication output one cycle later. These indications only report the match. They never stall or redirect execution. A watchpoint that is armed, by its software trap-enable or by its debug-port trap-enable, can also raise a breakpoint request. The request can come on the first match, or only after the watchpoint has matched a programmed number of times. Breakpoint requests from peripherals or from an external debug system join the same path.

A breakpoint request forces the core to branch to an exception handler. When a handler runs while the machine state is not recoverable, the core cannot restart. For that reason a masked mode holds breakpoints off while the recoverable-state status bit is clear. In that case the request stays pending and is delivered once the bit sets. The pending request stays asserted until the exception logic acknowledges it. In non-masked mode the recoverable-state bit is not consulted.

Top module: `wbt_trigger_top`

## Requirements
- R1: `wp_ind` equals the value `wp_hit` had on the previous clock edge, bit for bit, whatever the enables, counts or mode.
- R2: A watchpoint match counts as qualified only when its `sw_trap_en` bit or its `dbg_trap_en` bit is 1 (the two are ORed). An unqualified match leaves that watchpoint's counter unchanged and raises no breakpoint.
- R3: A pulse on `cnt_wr[i]` stores `cnt_wdata` as the programmed count of watchpoint i and reloads its remaining count at once. A match on watchpoint i in the same cycle is not counted.
- R4: With a programmed count of 0 or 1, every qualified match fires a breakpoint.
- R5: With a programmed count N ≥ 2, the Nth qualified match fires. The remaining count then reloads to N, so the watchpoint fires again every N qualified matches.
- R6: A 1 on any bit of `ext_brk` makes the breakpoint pending, in the same way as a watchpoint firing.
- R7: `brk_req` is 1 exactly when a breakpoint is pending and either `mask_mode` is 0 or `recov_ok` is 1. With `mask_mode` 0, `recov_ok` has no effect.
- R8: With `mask_mode` 1 and `recov_ok` 0, a breakpoint stays pending with `brk_req` low. It appears on `brk_req` in the cycle `recov_ok` becomes 1.
- R9: `brk_ack` clears the pending breakpoint at the next edge. A new breakpoint event in the same cycle keeps it pending.
- R10: After reset, `wp_ind` and `brk_req` are 0, nothing is pending, and every programmed count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_hit | input | NUM_WP | Watchpoint match strobes |
| sw_trap_en | input | NUM_WP | Software trap-enable per watchpoint |
| dbg_trap_en | input | NUM_WP | Debug-port trap-enable per watchpoint |
| cnt_wr | input | NUM_WP | Count write strobe per watchpoint |
| cnt_wdata | input | CNT_W | Count value, shared by all write strobes |
| ext_brk | input | NUM_EXT | External breakpoint requests |
| mask_mode | input | 1 | 1: hold breakpoints while the state is not recoverable |
| recov_ok | input | 1 | Recoverable-state status bit of the core |
| brk_ack | input | 1 | Exception logic has taken the breakpoint |
| wp_ind | output | NUM_WP | Registered watchpoint indications |
| brk_req | output | 1 | Breakpoint request to the exception logic |

## Verification
The assertions assume that every input has settled before the rising edge and is sampled only there. They also assume that a count write carries its data in the same cycle as its strobe. None of them depends on inputs staying stable across cycles. The stimulus changes all inputs on the falling edge only. Programmed counts are kept between 0 and 4, so the random phase sees many reloads. Mask mode, the recoverable-state bit and acknowledges are drawn often enough that held-off requests, late delivery and acknowledge-versus-new-event collisions all occur.

// File: rtl/wbt_pkg.sv
// Shared helpers for the watchpoint-to-breakpoint trigger unit.
// Assumes nothing beyond plain two-state logic on its arguments.
package wbt_pkg;

    // Gating of a pending breakpoint by the mask mode and the recovery bit.
    function automatic logic brk_gate(input logic pending,
                                      input logic masked,
                                      input logic recov);
        return pending & (~masked | recov);
    endfunction

    // Qualification of a match by either of its two trap enables.
    function automatic logic wp_qualify(input logic hit,
                                        input logic sw_en,
                                        input logic dbg_en);
        return hit & (sw_en | dbg_en);
    endfunction

endpackage

// File: rtl/wbt_wp_indicate.sv
// Registers the raw watchpoint strobes onto the indication outputs.
// Assumes the strobes are synchronous to clk; no gating of any kind.
module wbt_wp_indicate #(
    parameter int NUM_WP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] wp_hit,
    output logic [NUM_WP-1:0] wp_ind
);

    logic [NUM_WP-1:0] ind_q;
    logic              past_valid_q;

    // Capture the strobes one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) ind_q <= '0;
        else        ind_q <= wp_hit;
    end

    // Mark that at least one non-reset edge has occurred (checker use).
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid_q <= 1'b0;
        else        past_valid_q <= 1'b1;
    end

    assign wp_ind = ind_q;

    // R1
    ind_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid_q |-> (wp_ind == $past(wp_hit)));

endmodule

// File: rtl/wbt_wp_counter.sv
// One watchpoint's occurrence counter. It holds a programmed count and a
// remaining count, and signals fire on the qualified match that reaches the
// terminal value. Assumes cnt data is valid in the cycle of its strobe.
module wbt_wp_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             sw_en,
    input  logic             dbg_en,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             fire
);
    import wbt_pkg::*;

    localparam logic [CNT_W-1:0] TERM = CNT_W'(1);

    logic [CNT_W-1:0] prog_q;
    logic [CNT_W-1:0] rem_q;
    logic             qual;
    logic             at_term;

    assign qual    = wp_qualify(hit, sw_en, dbg_en);
    assign at_term = (rem_q <= TERM);
    assign fire    = qual & ~wr & at_term;

    // Hold the programmed count; a write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)  prog_q <= '0;
        else if (wr) prog_q <= wdata;
    end

    // Remaining count: reload on write, count down on a match, reload on fire.
    always_ff @(posedge clk) begin
        if (!rst_n)        rem_q <= '0;
        else if (wr)       rem_q <= wdata;
        else if (qual) begin
            if (at_term)   rem_q <= prog_q;
            else           rem_q <= rem_q - TERM;
        end
    end

    // R3
    write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr) |=> (prog_q == $past(wdata)) && (rem_q == $past(wdata)));

    // R5
    fire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fire) |=> (rem_q == prog_q));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !qual && !wr) |=> $stable(rem_q) && $stable(prog_q));

    // R4
    short_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && !wr && (prog_q <= TERM) && (rem_q == prog_q)) |-> fire);

endmodule

// File: rtl/wbt_brk_merge.sv
// Merges watchpoint fires and external requests into one pending flag.
// It gates the flag by mask mode and the recovery bit, and clears it on
// acknowledge. Assumes brk_ack is a single-cycle strobe from the exception
// logic.
module wbt_brk_merge #(
    parameter int NUM_WP  = 4,
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WP-1:0]  wp_fire,
    input  logic [NUM_EXT-1:0] ext_brk,
    input  logic               mask_mode,
    input  logic               recov_ok,
    input  logic               brk_ack,
    output logic               brk_req
);
    import wbt_pkg::*;

    logic event_now;
    logic pend_q;

    assign event_now = (|wp_fire) | (|ext_brk);

    // A new event sets pending; an acknowledge clears it; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (event_now) pend_q <= 1'b1;
        else if (brk_ack)   pend_q <= 1'b0;
    end

    assign brk_req = brk_gate(pend_q, mask_mode, recov_ok);

    // R6
    event_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && event_now) |=> pend_q);

    // R9
    ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && brk_ack && !event_now) |=> !pend_q);

    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_mode && !recov_ok) |-> !brk_req);

    // R7
    unmasked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !mask_mode) |-> brk_req);

endmodule

// File: rtl/wbt_trigger_top.sv
// Watchpoint-to-breakpoint trigger unit. It drives the watchpoint
// indications and one breakpoint request built from counted watchpoint
// fires and external requests. Assumes all inputs are synchronous to clk.
module wbt_trigger_top #(
    parameter int NUM_WP  = 4,
    parameter int NUM_EXT = 2,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WP-1:0]  wp_hit,
    input  logic [NUM_WP-1:0]  sw_trap_en,
    input  logic [NUM_WP-1:0]  dbg_trap_en,
    input  logic [NUM_WP-1:0]  cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic [NUM_EXT-1:0] ext_brk,
    input  logic               mask_mode,
    input  logic               recov_ok,
    input  logic               brk_ack,
    output logic [NUM_WP-1:0]  wp_ind,
    output logic               brk_req
);

    logic [NUM_WP-1:0] wp_fire;

    wbt_wp_indicate #(.NUM_WP(NUM_WP)) u_ind (
        .clk    (clk),
        .rst_n  (rst_n),
        .wp_hit (wp_hit),
        .wp_ind (wp_ind)
    );

    for (genvar i = 0; i < NUM_WP; i++) begin : g_cnt
        wbt_wp_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (wp_hit[i]),
            .sw_en  (sw_trap_en[i]),
            .dbg_en (dbg_trap_en[i]),
            .wr     (cnt_wr[i]),
            .wdata  (cnt_wdata),
            .fire   (wp_fire[i])
        );
    end

    wbt_brk_merge #(.NUM_WP(NUM_WP), .NUM_EXT(NUM_EXT)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_fire   (wp_fire),
        .ext_brk   (ext_brk),
        .mask_mode (mask_mode),
        .recov_ok  (recov_ok),
        .brk_ack   (brk_ack),
        .brk_req   (brk_req)
    );

    // R2
    no_arm_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wp_fire & ~(sw_trap_en | dbg_trap_en)) == '0));

endmodule

// File: tb/wbt_trigger_top_tb.sv
module wbt_trigger_top_tb;
    localparam int NW = 4;
    localparam int NE = 2;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] wp_hit = '0, sw_trap_en = '0, dbg_trap_en = '0, cnt_wr = '0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [NE-1:0] ext_brk = '0;
    logic          mask_mode = 1'b0, recov_ok = 1'b0, brk_ack = 1'b0;
    logic [NW-1:0] wp_ind;
    logic          brk_req;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    int  prog_m[NW];
    int  rem_m[NW];
    bit  pend_m;

    always #2 clk = ~clk;

    wbt_trigger_top #(.NUM_WP(NW), .NUM_EXT(NE), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_hit(wp_hit), .sw_trap_en(sw_trap_en),
        .dbg_trap_en(dbg_trap_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .ext_brk(ext_brk), .mask_mode(mask_mode), .recov_ok(recov_ok),
        .brk_ack(brk_ack), .wp_ind(wp_ind), .brk_req(brk_req));

    function automatic bit exp_req(bit p, bit m, bit r);
        return p && (!m || r);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus on the falling edge, advance the model, check after the edge.
    task automatic step(input logic [NW-1:0] hit, sw, dbg, wr, input logic [CW-1:0] wd,
                        input logic [NE-1:0] ext, input bit mk, rc, ak, input string tag);
        bit ev;
        wp_hit = hit; sw_trap_en = sw; dbg_trap_en = dbg; cnt_wr = wr;
        cnt_wdata = wd; ext_brk = ext; mask_mode = mk; recov_ok = rc; brk_ack = ak;
        ev = |ext;
        for (int i = 0; i < NW; i++) begin
            bit q;
            q = hit[i] && (sw[i] || dbg[i]);
            if (wr[i]) begin
                prog_m[i] = wd; rem_m[i] = wd;
            end else if (q) begin
                if (rem_m[i] <= 1) begin
                    ev = 1; rem_m[i] = prog_m[i];
                end else rem_m[i] = rem_m[i] - 1;
            end
        end
        pend_m = ev ? 1'b1 : (ak ? 1'b0 : pend_m);
        @(posedge clk);
        @(negedge clk);
        chk(wp_ind == hit, {tag, " R1 wp_ind"}, int'(wp_ind), int'(hit));
        chk(brk_req == exp_req(pend_m, mk, rc), {tag, " R7 brk_req"},
            int'(brk_req), int'(exp_req(pend_m, mk, rc)));
    endtask

    // Shorthand: idle cycle holding mode, recovery and acknowledge.
    task automatic idle(input bit mk, rc, ak, input string tag);
        step('0, '0, '0, '0, '0, '0, mk, rc, ak, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < NW; i++) begin prog_m[i] = 0; rem_m[i] = 0; end
        pend_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(wp_ind == '0, "R10 wp_ind after reset", int'(wp_ind), 0);
        chk(brk_req == 1'b0, "R10 brk_req after reset", int'(brk_req), 0);

        // R4/R10: count 0 after reset fires on first armed hit
        step(4'b0001, 4'b0001, '0, '0, '0, '0, 0, 0, 0, "R4 first hit sw");
        step('0, '0, '0, '0, '0, '0, 0, 0, 1, "R9 ack");
        // R2: debug enable alone arms
        step(4'b0010, '0, 4'b0010, '0, '0, '0, 0, 0, 0, "R2 dbg arm");
        idle(0, 0, 1, "R9 ack");
        // R2: hit without enables only indicates
        step(4'b1111, '0, '0, '0, '0, '0, 0, 0, 0, "R2 unarmed");
        chk(brk_req == 1'b0, "R2 unarmed no brk", int'(brk_req), 0);

        // R3: write count 3 with a same-cycle hit that must not count
        step(4'b0100, 4'b0100, '0, 4'b0100, 8'd3, '0, 0, 0, 0, "R3 write+hit");
        // R5: fires on the third qualified hit, twice in a row
        for (int k = 0; k < 6; k++) begin
            step(4'b0100, 4'b0100, '0, '0, '0, '0, 0, 0, 0, "R5 count3");
            if (k == 2 || k == 5) chk(brk_req == 1'b1, "R5 third hit fires", int'(brk_req), 1);
            else                  chk(brk_req == 1'b0, "R5 not yet", int'(brk_req), 0);
            idle(0, 0, 1, "R9 ack");
        end
        // R4: count 1 fires every hit
        step('0, '0, '0, 4'b1000, 8'd1, '0, 0, 0, 0, "R3 write1");
        step(4'b1000, '0, 4'b1000, '0, '0, '0, 0, 0, 0, "R4 count1");
        chk(brk_req == 1'b1, "R4 count1 fires", int'(brk_req), 1);
        idle(0, 0, 1, "R9 ack");

        // R6: external request
        step('0, '0, '0, '0, '0, 2'b10, 0, 0, 0, "R6 ext");
        chk(brk_req == 1'b1, "R6 ext sets request", int'(brk_req), 1);
        idle(0, 0, 1, "R9 ack");

        // R8: masked with recovery clear holds, then delivers
        step('0, '0, '0, '0, '0, 2'b01, 1, 0, 0, "R8 masked event");
        chk(brk_req == 1'b0, "R8 held", int'(brk_req), 0);
        idle(1, 0, 0, "R8 hold");
        idle(1, 1, 0, "R8 deliver");
        chk(brk_req == 1'b1, "R8 delivered", int'(brk_req), 1);
        // R7: non-masked ignores recovery bit
        idle(0, 0, 0, "R7 unmasked");
        chk(brk_req == 1'b1, "R7 unmasked recov 0", int'(brk_req), 1);
        // R9: ack with a simultaneous event keeps pending
        step('0, '0, '0, '0, '0, 2'b01, 0, 1, 1, "R9 ack+event");
        chk(brk_req == 1'b1, "R9 event beats ack", int'(brk_req), 1);
        idle(0, 1, 1, "R9 ack");
        chk(brk_req == 1'b0, "R9 cleared", int'(brk_req), 0);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            logic [NW-1:0] h, s, d, w;
            logic [NE-1:0] e;
            h = NW'($urandom);
            s = NW'($urandom) & NW'($urandom);
            d = NW'($urandom) & NW'($urandom);
            w = (($urandom % 8) == 0) ? NW'(1 << ($urandom % NW)) : '0;
            e = (($urandom % 16) == 0) ? NE'($urandom) : '0;
            step(h, s, d, w, CW'($urandom % 5), e, ($urandom % 2) == 1,
                 ($urandom % 3) != 0, ($urandom % 4) == 0, "R5 random");
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule